// File: doc/BRIEF.md
# Masked Event Interrupt Status Register

This block gathers single-cycle event pulses from a packet receiver and transmitter into a sticky status register. It drives an active-low interrupt line for the events that a mask enables. Each status bit records that a transition occurred. It does not follow the present level of the condition behind it. A host reads the register over a serial microport. Here the microport is reduced to three decoded strobes, each one clock wide:
- a command strobe, raised when a command/address byte decodes as a read of the status address;
- an SCLK falling-edge strobe;
- an end-of-read strobe.

The interrupt line is released on the first SCLK falling edge after the read command. It stays released until the read ends. At the end of the read every latched bit clears. An event that arrives while a read is in progress is parked in a pending bit and posted in the cycle after the clear. If its bit was already set when it arrived, it is absorbed instead. One bit position is shared between a receive frame-abort event and a transmit underrun event. A select input decides which of the two reaches it, and the other is ignored.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, `irq_n_o` is 1 and `rd_data_o` is 0, and a read returns 0.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k whatever the mask holds. The bit stays set after the pulse ends, and the next read returns it in bit k of `rd_data_o`.
- R3: While no set status bit has its `mask_i` bit at 1, `irq_n_o` stays 1.
- R4: A pulse on an enabled event drives `irq_n_o` to 0 after the clock edge that samples the pulse.
- R5: With a set and enabled bit, `irq_n_o` stays 0 after the clock edge that samples `rd_cmd_i`. It goes to 1 after the edge that samples the first later `sclk_fall_i`, and stays 1 until the read ends.
- R6: `rd_data_o` holds the status register as it stood at the clock edge that samples `rd_cmd_i`.
- R7: The clock edge that samples `rd_done_i` during a read clears every status bit.
- R8: An event that arrives during a read on a clear bit does not change the status seen during that read. It is set one cycle after the read ends.
- R9: An event that arrives during a read on a bit that is already set is absorbed and does not reappear after the clear.
- R10: Bit position 3 takes `evt_i[3]` (frame abort) when `alt_sel_i` is 0 and `alt_evt_i` (transmit underrun) when `alt_sel_i` is 1. The source that is not selected has no effect.
- R11: A read with no bits set returns 0, and `irq_n_o` stays 1 throughout it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 8 | Event pulses. Bit 0 go-ahead, 1 end-of-packet detect, 2 end-of-packet read, 3 frame abort, 4 FIFO filling, 5 FIFO overflow, 6 and 7 transmitter events |
| alt_evt_i | input | 1 | Transmit underrun pulse, which can share bit 3 |
| alt_sel_i | input | 1 | Bit 3 source select: 0 frame abort, 1 transmit underrun |
| mask_i | input | 8 | Per-bit interrupt enable |
| rd_cmd_i | input | 1 | Command/address byte decoded as a read of the status address |
| sclk_fall_i | input | 1 | SCLK falling-edge strobe |
| rd_done_i | input | 1 | End of the read cycle |
| rd_data_o | output | 8 | Status snapshot returned by the read |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench tries three kinds of input pattern.

A lone pulse with the mask closed, half open and fully open separates latching from interrupt gating. Reads that place events before the command, between the command and the end of the read, and on bits already set separate plain clearing, deferral and absorption. A read with nothing pending exposes any spurious data or interrupt.

Pulses on both the frame-abort input and the underrun input, under each value of the select, show whether the shared position follows only the selected source.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned IRQ_EVT_W      = 8;
  parameter int unsigned IRQ_SHARED_POS = 3;
  parameter int unsigned IRQ_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = irq_pkg::IRQ_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irq_evt_route.sv
module irq_evt_route #(
  parameter int unsigned EVT_W      = irq_pkg::IRQ_EVT_W,
  parameter int unsigned SHARED_POS = irq_pkg::IRQ_SHARED_POS
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic             alt_evt_i,
  input  logic             alt_sel_i,
  output logic [EVT_W-1:0] evt_o
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (i == SHARED_POS) begin : g_shared
      assign evt_o[i] = alt_sel_i ? alt_evt_i : evt_i[i];
    end else begin : g_plain
      assign evt_o[i] = evt_i[i];
    end
  end
endmodule

// File: rtl/irq_rd_seq.sv
module irq_rd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cmd_i,
  input  logic sclk_fall_i,
  input  logic rd_done_i,
  output logic in_read_o,
  output logic clr_o,
  output logic blk_o
);
  logic active_q, active_d;
  logic armed_q, armed_d;
  logic blk_q, blk_d;

  always_comb begin
    active_d = active_q;
    armed_d  = armed_q;
    blk_d    = blk_q;
    if (rd_cmd_i) begin
      active_d = 1'b1;
      armed_d  = 1'b1;
    end else if (active_q && rd_done_i) begin
      active_d = 1'b0;
      armed_d  = 1'b0;
      blk_d    = 1'b0;
    end else if (armed_q && sclk_fall_i) begin
      armed_d  = 1'b0;
      blk_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      blk_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      armed_q  <= armed_d;
      blk_q    <= blk_d;
    end
  end

  assign in_read_o = rd_cmd_i | active_q;
  assign clr_o     = active_q & rd_done_i & ~rd_cmd_i;
  assign blk_o     = blk_q;

  AST_BLK_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> active_q); // R5
  AST_ARM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && sclk_fall_i && !rd_cmd_i && !rd_done_i) |=> blk_q); // R5
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int unsigned EVT_W = irq_pkg::IRQ_EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             in_read_i,
  input  logic             clr_i,
  input  logic             snap_i,
  output logic [EVT_W-1:0] stat_o,
  output logic [EVT_W-1:0] snap_o
);
  logic [EVT_W-1:0] stat_q, stat_d;
  logic [EVT_W-1:0] pend_q, pend_d;
  logic [EVT_W-1:0] snap_q;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_comb begin
      stat_d[i] = stat_q[i];
      pend_d[i] = pend_q[i];
      if (in_read_i) begin
        if (evt_i[i] && !stat_q[i]) pend_d[i] = 1'b1;
        if (clr_i) stat_d[i] = 1'b0;
      end else begin
        stat_d[i] = stat_q[i] | pend_q[i] | evt_i[i];
        pend_d[i] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        stat_q[i] <= stat_d[i];
        pend_q[i] <= pend_d[i];
      end
    end

    AST_POST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_read_i && pend_q[i]) |=> stat_q[i]); // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (snap_i) snap_q <= stat_q;
  end

  assign stat_o = stat_q;
  assign snap_o = snap_q;

  AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stat_q == '0)); // R7
  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_read_i && !clr_i) |=> (stat_q == $past(stat_q))); // R8
  AST_NO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & stat_q) == '0)); // R9
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int unsigned EVT_W      = irq_pkg::IRQ_EVT_W,
  parameter int unsigned SHARED_POS = irq_pkg::IRQ_SHARED_POS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             alt_evt_i,
  input  logic             alt_sel_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic             rd_cmd_i,
  input  logic             sclk_fall_i,
  input  logic             rd_done_i,
  output logic [EVT_W-1:0] rd_data_o,
  output logic             irq_n_o
);
  logic             rst_sync_n;
  logic [EVT_W-1:0] evt_routed;
  logic [EVT_W-1:0] stat;
  logic             in_read, clr, blk;

  irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_sync_n)
  );

  irq_evt_route #(.EVT_W(EVT_W), .SHARED_POS(SHARED_POS)) u_route (
    .evt_i     (evt_i),
    .alt_evt_i (alt_evt_i),
    .alt_sel_i (alt_sel_i),
    .evt_o     (evt_routed)
  );

  irq_rd_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_cmd_i    (rd_cmd_i),
    .sclk_fall_i (sclk_fall_i),
    .rd_done_i   (rd_done_i),
    .in_read_o   (in_read),
    .clr_o       (clr),
    .blk_o       (blk)
  );

  irq_stat_bank #(.EVT_W(EVT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_i     (evt_routed),
    .in_read_i (in_read),
    .clr_i     (clr),
    .snap_i    (rd_cmd_i),
    .stat_o    (stat),
    .snap_o    (rd_data_o)
  );

  assign irq_n_o = ~((|(stat & mask_i)) & ~blk);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((stat & mask_i) == '0) |-> irq_n_o); // R3
  AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk |-> irq_n_o); // R5
  AST_ENABLED_FIRES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|(stat & mask_i)) && !in_read) |-> !irq_n_o); // R4
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_i, mask_i, rd_data_o;
  logic       alt_evt_i, alt_sel_i, rd_cmd_i, sclk_fall_i, rd_done_i, irq_n_o;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .alt_evt_i(alt_evt_i),
    .alt_sel_i(alt_sel_i), .mask_i(mask_i), .rd_cmd_i(rd_cmd_i),
    .sclk_fall_i(sclk_fall_i), .rd_done_i(rd_done_i),
    .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    evt_i = v; tick(); evt_i = '0;
  endtask

  task automatic pulse_alt();
    alt_evt_i = 1'b1; tick(); alt_evt_i = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] data);
    rd_cmd_i = 1'b1; tick(); rd_cmd_i = 1'b0;
    sclk_fall_i = 1'b1; tick(); sclk_fall_i = 1'b0;
    tick();
    rd_done_i = 1'b1; tick(); rd_done_i = 1'b0;
    data = rd_data_o;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq after reset", irq_n_o, 1);
    chk("R1 data after reset", rd_data_o, 0);
    do_read(d);
    chk("R1 first read", d, 0);
  endtask

  task automatic t_mask_off();
    logic [7:0] d;
    mask_i = 8'h00;
    pulse_evt(8'h01);
    chk("R3 masked event irq", irq_n_o, 1);
    tick();
    do_read(d);
    chk("R2 masked event latched", d, 8'h01);
    do_read(d);
    chk("R7 cleared after read", d, 0);
  endtask

  task automatic t_partial_mask();
    logic [7:0] d;
    mask_i = 8'h02;
    pulse_evt(8'h10);
    chk("R3 disabled bit no irq", irq_n_o, 1);
    pulse_evt(8'h02);
    chk("R4 enabled bit irq", irq_n_o, 0);
    do_read(d);
    chk("R2 both bits latched", d, 8'h12);
    chk("R7 irq idle after clear", irq_n_o, 1);
  endtask

  task automatic t_release();
    logic [7:0] d;
    mask_i = 8'hFF;
    pulse_evt(8'h04);
    chk("R4 irq asserted", irq_n_o, 0);
    rd_cmd_i = 1'b1; tick(); rd_cmd_i = 1'b0;
    chk("R5 irq held before sclk fall", irq_n_o, 0);
    sclk_fall_i = 1'b1; tick(); sclk_fall_i = 1'b0;
    chk("R5 irq released on sclk fall", irq_n_o, 1);
    tick();
    chk("R5 irq stays released", irq_n_o, 1);
    rd_done_i = 1'b1; tick(); rd_done_i = 1'b0;
    chk("R6 snapshot", rd_data_o, 8'h04);
    chk("R7 irq after clear", irq_n_o, 1);
    do_read(d);
    chk("R7 second read empty", d, 0);
  endtask

  task automatic t_defer();
    logic [7:0] d;
    mask_i = 8'hFF;
    pulse_evt(8'h01);
    rd_cmd_i = 1'b1; tick(); rd_cmd_i = 1'b0;
    sclk_fall_i = 1'b1; tick(); sclk_fall_i = 1'b0;
    pulse_evt(8'h21);
    chk("R8 irq released during read", irq_n_o, 1);
    rd_done_i = 1'b1; tick(); rd_done_i = 1'b0;
    chk("R6 snapshot excludes mid-read event", rd_data_o, 8'h01);
    chk("R8 not yet posted at clear", irq_n_o, 1);
    tick();
    chk("R8 posted next cycle", irq_n_o, 0);
    do_read(d);
    chk("R9 only deferred bit present", d, 8'h20);
  endtask

  task automatic t_shared();
    logic [7:0] d;
    mask_i = 8'hFF;
    alt_sel_i = 1'b0;
    pulse_alt();
    chk("R10 underrun ignored when sel=0 irq", irq_n_o, 1);
    do_read(d);
    chk("R10 underrun ignored when sel=0", d, 0);
    pulse_evt(8'h08);
    do_read(d);
    chk("R10 frame abort when sel=0", d, 8'h08);
    alt_sel_i = 1'b1;
    pulse_evt(8'h08);
    chk("R10 frame abort ignored when sel=1 irq", irq_n_o, 1);
    do_read(d);
    chk("R10 frame abort ignored when sel=1", d, 0);
    pulse_alt();
    do_read(d);
    chk("R10 underrun when sel=1", d, 8'h08);
    alt_sel_i = 1'b0;
  endtask

  task automatic t_empty_poll();
    logic [7:0] d;
    mask_i = 8'hFF;
    rd_cmd_i = 1'b1; tick(); rd_cmd_i = 1'b0;
    chk("R11 irq idle in empty read", irq_n_o, 1);
    sclk_fall_i = 1'b1; tick(); sclk_fall_i = 1'b0;
    rd_done_i = 1'b1; tick(); rd_done_i = 1'b0;
    d = rd_data_o;
    chk("R11 empty read data", d, 0);
    chk("R11 irq idle after empty read", irq_n_o, 1);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    evt_i = '0; mask_i = '0; alt_evt_i = 1'b0; alt_sel_i = 1'b0;
    rd_cmd_i = 1'b0; sclk_fall_i = 1'b0; rd_done_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_mask_off();
    t_partial_mask();
    t_release();
    t_defer();
    t_shared();
    t_empty_poll();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule